// File: doc/BRIEF.md
# SPI Master/Slave Port with Write-Collision Detection

This block is a byte-wide SPI peripheral for a processor bus. One control bit decides whether it runs as the master, generating SCK itself, or as a slave, following an external master's SCK while its select input is low. The processor sees three registers: control, status and data. In master mode, writing the data register starts a transfer. In slave mode, the same write preloads the byte that will be returned to the remote master.

Each byte that arrives is copied into a separate receive buffer, so software has a full byte time to read it before the next byte overwrites it. Transmit data has no such buffer. A data write made while a byte is moving is thrown away and raises a collision flag. The byte already on the wire is not disturbed.

The shifting is run by one state machine with four states:
- `ST_IDLE`: nothing is moving.
- `ST_M_RUN`: a master transfer is in progress.
- `ST_S_WAIT`: the slave is selected but no byte is active.
- `ST_S_SHIFT`: a slave byte is in progress.

Its transitions are:
- start: `ST_IDLE` to `ST_M_RUN`, on a data write in enabled master mode.
- select: `ST_IDLE` to `ST_S_WAIT`, when enabled as a slave and select is low.
- finish: `ST_M_RUN` to `ST_IDLE`, after the sixteenth half period.
- first edge: `ST_S_WAIT` to `ST_S_SHIFT`, on a leading SCK edge.
- byte end: `ST_S_SHIFT` to `ST_S_WAIT`, on the eighth sampling edge.
- drop: any active state to `ST_IDLE`, when the block is disabled, the mode changes, or (slave only) select goes high.

Top module: `spi_port`

## Requirements
- R1: After reset, the control register (offset 0) and the status register (offset 1) read 0. `irq`, `sck_oe`, `mosi_oe` and `miso_oe` are low.
- R2: Control bits are: bit0 enable, bit1 interrupt enable, bit2 master, bit3 clock polarity, bit4 clock phase. In enabled master mode, a data write (offset 2) while idle produces exactly 16 SCK level changes, each half period lasting 2 system clocks. Before and after the burst, SCK rests at the polarity bit.
- R3: Data goes out most significant bit first. With phase 0, each bit is valid before the leading edge and is sampled on it. With phase 1, each bit changes on the leading edge and is sampled on the trailing edge. This holds for all four polarity/phase combinations.
- R4: A data-register read returns the last fully received byte, which is copied in parallel into a receive buffer when the byte completes.
- R5: Completion of a byte sets status bit7 (done flag).
- R6: A data write while a byte is in progress is dropped, the ongoing byte completes unchanged, and status bit6 (collision flag) is set.
- R7: Both flags are cleared by a status read taken while a flag is set, followed by a data-register read or write. A data access with no such status read first leaves the flags set.
- R8: `irq` is high exactly when the done flag and the interrupt-enable bit are both set.
- R9: In enabled slave mode with `ss_n_i` low, the block samples `mosi_i` on the master's edges according to the phase bit. It drives the preloaded byte out on `miso_o`, most significant bit first. The received byte raises the done flag.
- R10: `miso_oe` is high only while the slave is enabled and selected. It is low whenever `ss_n_i` is high.
- R11: If `ss_n_i` rises in the middle of a slave byte, the byte is abandoned and the done flag stays clear. The next selection starts a fresh byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (status/data side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from a remote master |
| sck_o | output | 1 | Serial clock generated in master mode |
| sck_oe | output | 1 | Drive enable for sck_o |
| mosi_i | input | 1 | Serial data in, slave mode |
| mosi_o | output | 1 | Serial data out, master mode |
| mosi_oe | output | 1 | Drive enable for mosi_o |
| miso_i | input | 1 | Serial data in, master mode |
| miso_o | output | 1 | Serial data out, slave mode |
| miso_oe | output | 1 | Drive enable for miso_o |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The bench runs a master transfer in every polarity/phase mode against a modelled remote slave. If the sample and change edges were swapped, the captured bytes would come out shifted by one bit. If the half-period count were off by one, the wrong number of SCK edges would be counted.

A second data write is issued in the middle of a byte. A design that queued or loaded that write would corrupt the bits on the wire, or fail to raise the collision flag.

The clearing sequence is exercised both with and without the status read first, which exposes flags that clear too eagerly. A slave byte is cut short by raising select. A design that kept its bit count would then misalign the next byte or signal a false completion.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_M_RUN,
        ST_S_WAIT,
        ST_S_SHIFT
    } eng_state_t;

    // Control register layout, bit4 down to bit0
    typedef struct packed {
        logic cpha;
        logic cpol;
        logic master;
        logic irq_en;
        logic enable;
    } ctrl_t;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_DATA = 2'd2;

    localparam int STAT_DONE_BIT = 7;
    localparam int STAT_COLL_BIT = 6;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe[0] <= RST_VAL;
        end else begin
            pipe[0] <= d_i;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe[s] <= RST_VAL;
            end else begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/spi_engine.sv
module spi_engine
    import spi_port_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              mst_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              miso_i,
    input  logic              sck_s_i,
    input  logic              ss_s_i,
    input  logic              mosi_s_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              sel_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              sck_o,
    output logic              out_bit_o
);

    localparam int HALF   = CLK_DIV / 2;
    localparam int HALVES = 2 * DATA_W;
    localparam int HCNT_W = $clog2(HALVES);
    localparam int TCNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BIT_W  = $clog2(DATA_W);
    localparam int ECW    = HCNT_W + 2;

    eng_state_t        st, nxt;
    logic [HCNT_W-1:0] hcnt;
    logic [TCNT_W-1:0] tcnt;
    logic [BIT_W-1:0]  bcnt;
    logic [DATA_W-1:0] shreg;
    logic              obit;
    logic              sck_d;
    logic              half_end, last_half;
    logic              edge_any, lead_e, trail_e, samp_e, shf_e;
    logic              drop_slave;

    assign half_end   = (tcnt == TCNT_W'(HALF - 1));
    assign last_half  = (hcnt == HCNT_W'(HALVES - 1));
    assign edge_any   = (sck_s_i != sck_d);
    assign lead_e     = edge_any && (sck_s_i != cpol_i);
    assign trail_e    = edge_any && (sck_s_i == cpol_i);
    assign samp_e     = cpha_i ? trail_e : lead_e;
    assign shf_e      = cpha_i ? lead_e  : trail_e;
    assign drop_slave = !en_i || mst_i || ss_s_i;

    // next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (en_i && mst_i && load_i)        nxt = ST_M_RUN;
                else if (en_i && !mst_i && !ss_s_i) nxt = ST_S_WAIT;
            end
            ST_M_RUN: begin
                if (!en_i || !mst_i)                nxt = ST_IDLE;
                else if (half_end && last_half)     nxt = ST_IDLE;
            end
            ST_S_WAIT: begin
                if (drop_slave)                     nxt = ST_IDLE;
                else if (lead_e)                    nxt = ST_S_SHIFT;
            end
            ST_S_SHIFT: begin
                if (drop_slave)                     nxt = ST_IDLE;
                else if (samp_e && bcnt == BIT_W'(DATA_W - 1)) nxt = ST_S_WAIT;
            end
            default:                                nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt   <= '0;
            tcnt   <= '0;
            bcnt   <= '0;
            shreg  <= '0;
            obit   <= 1'b0;
            sck_d  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            sck_d  <= sck_s_i;
            unique case (st)
                ST_IDLE: begin
                    hcnt <= '0;
                    tcnt <= '0;
                    bcnt <= '0;
                    if (load_i && en_i) begin
                        shreg <= load_data_i;
                        obit  <= load_data_i[DATA_W-1];
                    end
                end
                ST_M_RUN: begin
                    if (half_end) begin
                        tcnt <= '0;
                        if (last_half) begin
                            hcnt   <= '0;
                            done_o <= en_i && mst_i;
                        end else begin
                            hcnt <= hcnt + 1'b1;
                            if (!hcnt[0]) shreg <= {shreg[DATA_W-2:0], miso_i};
                            else          obit  <= shreg[DATA_W-1];
                        end
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_S_WAIT, ST_S_SHIFT: begin
                    if (drop_slave) begin
                        bcnt <= '0;
                    end else begin
                        if (load_i && st == ST_S_WAIT) begin
                            shreg <= load_data_i;
                            obit  <= load_data_i[DATA_W-1];
                        end else if (st == ST_S_SHIFT || lead_e) begin
                            if (samp_e) begin
                                shreg <= {shreg[DATA_W-2:0], mosi_s_i};
                                if (bcnt == BIT_W'(DATA_W - 1)) begin
                                    bcnt   <= '0;
                                    done_o <= 1'b1;
                                end else begin
                                    bcnt <= bcnt + 1'b1;
                                end
                            end
                            if (shf_e) obit <= shreg[DATA_W-1];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o    = (st == ST_M_RUN) || (st == ST_S_SHIFT);
        sel_o     = (st == ST_S_WAIT) || (st == ST_S_SHIFT);
        rx_data_o = shreg;
        out_bit_o = obit;
        sck_o     = cpol_i;
        if (st == ST_M_RUN) sck_o = cpol_i ^ (cpha_i ? ~hcnt[0] : hcnt[0]);
    end

    // checker state: SCK level changes in one master byte
    logic           sck_q;
    logic [ECW-1:0] edge_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q    <= 1'b0;
            edge_cnt <= '0;
        end else begin
            sck_q <= sck_o;
            if (st == ST_M_RUN && hcnt == '0 && tcnt == '0)
                edge_cnt <= (sck_o != sck_q) ? ECW'(1) : ECW'(0);
            else if (sck_o != sck_q)
                edge_cnt <= edge_cnt + 1'b1;
        end
    end

    // R2
    sck_edge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mst_i) |=> (edge_cnt == ECW'(HALVES)));

    // R11
    slave_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_S_SHIFT && ss_s_i) |=> (st == ST_IDLE && !done_o));

endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ss_n_i
);

    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t             ctrl;
    logic              spif, wcol, armed;
    logic [DATA_W-1:0] rbuf;
    logic              busy, done, sel, out_bit;
    logic [DATA_W-1:0] rx_byte;
    logic [2:0]        pins_s;
    logic              sck_s, ss_s, mosi_s;
    logic              stat_rd, data_acc, data_wr, load;

    spi_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({mosi_i, ss_n_i, sck_i}),
        .q_o   (pins_s)
    );
    assign {mosi_s, ss_s, sck_s} = pins_s;

    assign stat_rd  = bus_rd && (bus_addr == REG_STAT);
    assign data_acc = (bus_rd || bus_wr) && (bus_addr == REG_DATA);
    assign data_wr  = bus_wr && (bus_addr == REG_DATA);
    assign load     = data_wr && !busy;

    spi_engine #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (ctrl.enable),
        .mst_i       (ctrl.master),
        .cpol_i      (ctrl.cpol),
        .cpha_i      (ctrl.cpha),
        .load_i      (load),
        .load_data_i (bus_wdata),
        .miso_i      (miso_i),
        .sck_s_i     (sck_s),
        .ss_s_i      (ss_s),
        .mosi_s_i    (mosi_s),
        .busy_o      (busy),
        .done_o      (done),
        .sel_o       (sel),
        .rx_data_o   (rx_byte),
        .sck_o       (sck_o),
        .out_bit_o   (out_bit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl  <= '0;
            spif  <= 1'b0;
            wcol  <= 1'b0;
            armed <= 1'b0;
            rbuf  <= '0;
        end else begin
            if (bus_wr && bus_addr == REG_CTRL) ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (stat_rd && (spif || wcol)) armed <= 1'b1;
            if (data_acc && armed) begin
                spif  <= 1'b0;
                wcol  <= 1'b0;
                armed <= 1'b0;
            end
            if (data_wr && busy) wcol <= 1'b1;
            if (done) begin
                spif <= 1'b1;
                rbuf <= rx_byte;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_CTRL: bus_rdata[CTRL_W-1:0] = ctrl;
            REG_STAT: begin
                bus_rdata[STAT_DONE_BIT] = spif;
                bus_rdata[STAT_COLL_BIT] = wcol;
            end
            REG_DATA: bus_rdata = rbuf;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq     = spif && ctrl.irq_en;
    assign sck_oe  = ctrl.enable && ctrl.master;
    assign mosi_oe = ctrl.enable && ctrl.master;
    assign mosi_o  = out_bit;
    assign miso_o  = out_bit;
    assign miso_oe = ctrl.enable && !ctrl.master && sel && !ss_s;

    // R6
    wcol_on_busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && busy) |=> wcol);

    // R5
    spif_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> spif);

    // R4
    rbuf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(rbuf));

    // R10
    miso_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_s && $past(ss_s)) |-> !miso_oe);

endmodule

// File: tb/spi_port_tb.sv
module spi_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
    logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic test_reset();
        logic [7:0] v;
        bus_read(2'd0, v);
        check(v == 8'h00, "R1 control after reset", v, 0);
        bus_read(2'd1, v);
        check(v == 8'h00, "R1 status after reset", v, 0);
        check({irq, sck_oe, mosi_oe, miso_oe} == 4'b0, "R1 outputs after reset",
              {irq, sck_oe, mosi_oe, miso_oe}, 0);
    endtask

    // master transfer against a modelled remote slave
    task automatic test_master(input bit cpol, input bit cpha, input bit ie,
                               input logic [7:0] tx, input logic [7:0] rx, input bit coll);
        logic [7:0] v, cap, rsh;
        logic       prev, lead;
        int         toggles;
        bus_write(2'd0, {3'b000, cpha, cpol, 1'b1, ie, 1'b1});
        @(negedge clk);
        check(sck_o == cpol, "R2 idle SCK level before burst", sck_o, cpol);
        rsh = rx; miso_i = rsh[7]; cap = '0; toggles = 0;
        bus_addr = 2'd2; bus_wdata = tx; bus_wr = 1'b1; prev = sck_o;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            bus_wr = 1'b0;
            if (coll && i == 5) begin
                bus_wdata = ~tx; bus_wr = 1'b1;
            end
            if (sck_o != prev) begin
                toggles++;
                lead = (sck_o != cpol);
                if (lead != cpha) begin
                    cap = {cap[6:0], mosi_o};
                    rsh = {rsh[6:0], 1'b0};
                end else begin
                    miso_i = rsh[7];
                end
                prev = sck_o;
            end
        end
        check(toggles == 16, "R2 SCK level changes per byte", toggles, 16);
        check(sck_o == cpol, "R2 idle SCK level after burst", sck_o, cpol);
        check(cap == tx, "R3 MOSI byte seen by slave", cap, tx);
        check(irq == ie, "R8 irq follows flag and enable", irq, ie);
        if (!coll) begin
            bus_read(2'd1, v);
            check(v == 8'h80, "R5 done flag set", v, 8'h80);
            bus_read(2'd2, v);
            check(v == rx, "R4 received byte in buffer", v, rx);
            bus_read(2'd1, v);
            check(v == 8'h00, "R7 flags cleared", v, 0);
        end else begin
            bus_read(2'd2, v);
            check(v == rx, "R4 received byte after collision", v, rx);
            bus_read(2'd1, v);
            check(v == 8'hC0, "R6 collision flag; R7 no clear without status read", v, 8'hC0);
            bus_read(2'd2, v);
            bus_read(2'd1, v);
            check(v == 8'h00, "R7 flags cleared after sequence", v, 0);
        end
        check(irq == 1'b0, "R8 irq low after clear", irq, 0);
    endtask

    // slave byte driven by a modelled remote master; nbits<8 aborts
    task automatic test_slave(input bit cpol, input bit cpha, input logic [7:0] pre,
                              input logic [7:0] mb, input int nbits);
        logic [7:0] v, cap;
        sck_i = cpol; ss_n_i = 1'b1;
        bus_write(2'd0, {3'b000, cpha, cpol, 1'b0, 1'b1, 1'b1});
        bus_write(2'd2, pre);
        repeat (4) @(negedge clk);
        check(miso_oe == 1'b0, "R10 MISO released while deselected", miso_oe, 0);
        ss_n_i = 1'b0;
        repeat (SH) @(negedge clk);
        check(miso_oe == 1'b1, "R10 MISO driven while selected", miso_oe, 1);
        cap = '0;
        for (int i = 7; i >= 8 - nbits; i--) begin
            if (!cpha) begin
                mosi_i = mb[i];
                repeat (SH) @(negedge clk);
                cap = {cap[6:0], miso_o};
                sck_i = ~cpol;
                repeat (SH) @(negedge clk);
                sck_i = cpol;
            end else begin
                sck_i = ~cpol; mosi_i = mb[i];
                repeat (SH) @(negedge clk);
                cap = {cap[6:0], miso_o};
                sck_i = cpol;
                repeat (SH) @(negedge clk);
            end
        end
        repeat (SH) @(negedge clk);
        if (nbits == 8) begin
            check(cap == pre, "R9 preloaded byte on MISO", cap, pre);
            bus_read(2'd1, v);
            check(v == 8'h80, "R9 done flag after slave byte", v, 8'h80);
            bus_read(2'd2, v);
            check(v == mb, "R9 byte received from master", v, mb);
            ss_n_i = 1'b1;
        end else begin
            ss_n_i = 1'b1;
            repeat (SH) @(negedge clk);
            bus_read(2'd1, v);
            check(v == 8'h00, "R11 no done flag on aborted byte", v, 0);
        end
        repeat (SH) @(negedge clk);
        check(miso_oe == 1'b0, "R10 MISO released after deselect", miso_oe, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_master(1'b0, 1'b0, 1'b1, 8'hA5, 8'h3C, 1'b0);
        test_master(1'b0, 1'b1, 1'b1, 8'h81, 8'h7E, 1'b0);
        test_master(1'b1, 1'b0, 1'b1, 8'h5A, 8'hC3, 1'b0);
        test_master(1'b1, 1'b1, 1'b0, 8'h01, 8'h80, 1'b0);
        test_master(1'b0, 1'b0, 1'b1, 8'hD2, 8'h4B, 1'b1);
        test_slave(1'b0, 1'b0, 8'h96, 8'h2D, 8);
        test_slave(1'b1, 1'b1, 8'h1E, 8'hB4, 8);
        test_slave(1'b0, 1'b1, 8'hFF, 8'h00, 3);
        test_slave(1'b0, 1'b1, 8'h69, 8'hE1, 8);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule